// File: doc/BRIEF.md
# Header-Aligned Receive Gearbox with Bitslip

This block sits behind a serial deserializer. Each word-clock cycle it takes one 20-bit word and returns aligned 120-bit frames, each built from six words. The word boundaries from the deserializer have no fixed relation to the frame boundaries. The block therefore searches for a 4-bit header that opens every frame. A small register-based barrel shifter picks a 20-bit window from the last two input words. An alignment state machine moves that window one word position or one bit at a time until the header appears where a frame should start.

After the header has been confirmed in enough consecutive frames, the block declares lock. From then on it emits a one-cycle frame strobe every six word cycles, in phase with the frame just assembled. That strobe acts as the receive frame-rate clock enable, so its duty cycle is one cycle in six. The current bit offset of the shifter is also an output, so the recovered alignment can be seen from outside. Clock recovery, descrambling and decoding take place elsewhere.

Top module: `rx_frame_gearbox`

## Requirements
- R1: Each strobed frame holds six consecutive aligned words. The earliest received word sits in bits 119:100, so the header occupies bits 119:116, and each bit keeps its serial order (first received bit is most significant).
- R2: A header is valid when the 4 bits equal 4'b0101 (data) or 4'b0110 (idle). Any other value is invalid.
- R3: The bit offset output changes only while unlocked, and only by +1 modulo 20. Once locked, it equals the header's bit position within a word (a stream preceded by D filler bits gives D mod 20).
- R4: When the header is missing, the search first tries the next word position. After six failed word positions it performs one bitslip. Every alignment is therefore reached, and lock follows within 150 frames of a valid stream starting.
- R5: Lock is declared only after 32 consecutive valid headers at one alignment. An invalid header during confirmation restarts the search.
- R6: While locked, 4 consecutive invalid headers drop the lock, and 3 do not. After a drop, the search resumes from the current alignment and lock is regained.
- R7: After any bitslip, no header check and no further bitslip happens for 2 cycles.
- R8: While locked, the bit offset stays constant.
- R9: The frame strobe is high only when the block was locked in the previous cycle. Strobes are at least six cycles apart, and exactly six cycles apart during continuous lock.
- R10: The frame output changes only in a cycle in which the strobe is high.
- R11: Synchronous active-high reset clears lock, strobe, frame output and bit offset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 20 | Deserialized word, first received bit in the MSB |
| frame_o | output | 120 | Aligned frame, header in bits 119:116 |
| frame_stb_o | output | 1 | One-cycle frame enable, once every six words while locked |
| locked_o | output | 1 | Header lock flag |
| slip_o | output | 5 | Current barrel-shifter bit offset (0 to 19) |

## Verification
The assertions check on every cycle the rules that hold regardless of the input data:
- the offset steps by +1 modulo 20, waits out the settle time, and is frozen while locked;
- the strobe depends on lock and keeps its spacing;
- the frame output holds between strobes.

Only the bench scenarios can show the rest:
- recovered frames match the transmitted ones;
- the final offset matches the injected bit offset;
- lock arrives neither before 32 frames nor after the search bound;
- three bad headers are tolerated, while four drop the lock and lock is then regained.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } align_state_t;

  localparam logic [3:0] HDR_DATA = 4'b0101;
  localparam logic [3:0] HDR_IDLE = 4'b0110;

  function automatic logic hdr_valid(input logic [3:0] h);
    return (h == HDR_DATA) || (h == HDR_IDLE);
  endfunction

endpackage

// File: rtl/rxg_barrel_shift.sv
module rxg_barrel_shift #(
  parameter int WORD_W = 20,
  parameter int OFF_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  input  logic [OFF_W-1:0]  offset,
  output logic [WORD_W-1:0] dout
);

  localparam int CAT_W = 2 * WORD_W;

  logic [WORD_W-1:0] newer_q;
  logic [WORD_W-1:0] older_q;
  logic [CAT_W-1:0]  pair;
  logic [WORD_W-1:0] window;

  assign pair = {older_q, newer_q};

  // Window starts `offset` bits into the older word.
  always_comb begin
    window = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (offset == OFF_W'(i)) begin
        window = pair[CAT_W-1-i -: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      newer_q <= '0;
      older_q <= '0;
      dout    <= '0;
    end else begin
      newer_q <= din;
      older_q <= newer_q;
      dout    <= window;
    end
  end

endmodule

// File: rtl/rxg_align_fsm.sv
module rxg_align_fsm
  import rxg_pkg::*;
#(
  parameter int WORD_W      = 20,
  parameter int FRAME_WORDS = 6,
  parameter int HDR_W       = 4,
  parameter int LOCK_FRAMES = 32,
  parameter int LOSS_FRAMES = 4,
  parameter int SETTLE      = 2,
  parameter int OFF_W       = $clog2(WORD_W),
  parameter int PH_W        = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HDR_W-1:0] hdr_i,
  output logic [PH_W-1:0]  phase_o,
  output logic [OFF_W-1:0] offset_o,
  output logic             locked_o
);

  localparam int GOOD_W = $clog2(LOCK_FRAMES);
  localparam int BAD_W  = (LOSS_FRAMES > 1) ? $clog2(LOSS_FRAMES) : 1;
  localparam int SET_W  = $clog2(SETTLE + 1);
  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(FRAME_WORDS - 1);
  localparam logic [OFF_W-1:0]  OFF_LAST = OFF_W'(WORD_W - 1);
  localparam logic [GOOD_W-1:0] GOOD_END = GOOD_W'(LOCK_FRAMES - 1);
  localparam logic [BAD_W-1:0]  BAD_END  = BAD_W'(LOSS_FRAMES - 1);

  align_state_t      state;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   word_tries;
  logic [OFF_W-1:0]  offset;
  logic [GOOD_W-1:0] good_cnt;
  logic [BAD_W-1:0]  bad_cnt;
  logic [SET_W-1:0]  settle;

  logic hdr_ok, check, miss, do_slip, do_hold;

  always_comb begin
    hdr_ok  = hdr_valid(hdr_i);
    check   = (phase == '0) && (settle == '0);
    miss    = check && !hdr_ok && (state != ST_LOCKED);
    do_slip = miss && (word_tries == PH_LAST);
    do_hold = miss && !do_slip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HUNT;
      phase      <= '0;
      word_tries <= '0;
      offset     <= '0;
      good_cnt   <= '0;
      bad_cnt    <= '0;
      settle     <= '0;
    end else begin
      // Frame phase: a hold re-tests position 0 on the next word.
      if (do_hold || phase == PH_LAST) phase <= '0;
      else                             phase <= phase + 1'b1;

      if (do_slip) begin
        word_tries <= '0;
        offset     <= (offset == OFF_LAST) ? '0 : offset + 1'b1;
        settle     <= SET_W'(SETTLE);
      end else begin
        if (do_hold) word_tries <= word_tries + 1'b1;
        if (settle != '0) settle <= settle - 1'b1;
      end

      if (check) begin
        unique case (state)
          ST_HUNT: begin
            if (hdr_ok) begin
              state    <= ST_CONFIRM;
              good_cnt <= GOOD_W'(1);
            end
          end
          ST_CONFIRM: begin
            if (!hdr_ok) begin
              state    <= ST_HUNT;
              good_cnt <= '0;
            end else if (good_cnt == GOOD_END) begin
              state    <= ST_LOCKED;
              bad_cnt  <= '0;
            end else begin
              good_cnt <= good_cnt + 1'b1;
            end
          end
          ST_LOCKED: begin
            if (hdr_ok) begin
              bad_cnt <= '0;
            end else if (bad_cnt == BAD_END) begin
              state      <= ST_HUNT;
              bad_cnt    <= '0;
              good_cnt   <= '0;
              word_tries <= '0;
            end else begin
              bad_cnt <= bad_cnt + 1'b1;
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign phase_o  = phase;
  assign offset_o = offset;
  assign locked_o = (state == ST_LOCKED);

endmodule

// File: rtl/rxg_frame_asm.sv
module rxg_frame_asm #(
  parameter int WORD_W      = 20,
  parameter int FRAME_WORDS = 6,
  parameter int PH_W        = $clog2(FRAME_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WORD_W-1:0]             word_i,
  input  logic [PH_W-1:0]               phase_i,
  input  logic                          locked_i,
  output logic [WORD_W*FRAME_WORDS-1:0] frame_o,
  output logic                          stb_o
);

  localparam int SR_W = WORD_W * (FRAME_WORDS - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_WORDS - 1);

  logic [SR_W-1:0] hist_q;
  logic            close;

  assign close = locked_i && (phase_i == PH_LAST);

  generate
    if (FRAME_WORDS > 2) begin : g_long
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[SR_W-WORD_W-1:0], word_i};
      end
    end else begin : g_short
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= word_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_o <= '0;
      stb_o   <= 1'b0;
    end else begin
      stb_o <= close;
      if (close) frame_o <= {hist_q, word_i};
    end
  end

endmodule

// File: rtl/rx_frame_gearbox.sv
module rx_frame_gearbox #(
  parameter int WORD_W      = 20,
  parameter int FRAME_WORDS = 6,
  parameter int HDR_W       = 4,
  parameter int LOCK_FRAMES = 32,
  parameter int LOSS_FRAMES = 4,
  parameter int SETTLE      = 2,
  parameter int OFF_W       = $clog2(WORD_W),
  parameter int FRAME_W     = WORD_W * FRAME_WORDS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WORD_W-1:0]  word_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_stb_o,
  output logic               locked_o,
  output logic [OFF_W-1:0]   slip_o
);

  localparam int PH_W = $clog2(FRAME_WORDS);

  logic [WORD_W-1:0] aligned;
  logic [PH_W-1:0]   phase;
  logic [OFF_W-1:0]  offset;
  logic              locked;

  rxg_barrel_shift #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .din    (word_i),
    .offset (offset),
    .dout   (aligned)
  );

  rxg_align_fsm #(
    .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .HDR_W(HDR_W),
    .LOCK_FRAMES(LOCK_FRAMES), .LOSS_FRAMES(LOSS_FRAMES), .SETTLE(SETTLE),
    .OFF_W(OFF_W), .PH_W(PH_W)
  ) u_align (
    .clk      (clk),
    .rst      (rst),
    .hdr_i    (aligned[WORD_W-1 -: HDR_W]),
    .phase_o  (phase),
    .offset_o (offset),
    .locked_o (locked)
  );

  rxg_frame_asm #(.WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .PH_W(PH_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .word_i   (aligned),
    .phase_i  (phase),
    .locked_i (locked),
    .frame_o  (frame_o),
    .stb_o    (frame_stb_o)
  );

  assign locked_o = locked;
  assign slip_o   = offset;

endmodule

// File: rtl/rxg_checker.sv
module rxg_checker #(
  parameter int WORD_W      = 20,
  parameter int FRAME_WORDS = 6,
  parameter int OFF_W       = $clog2(WORD_W),
  parameter int FRAME_W     = WORD_W * FRAME_WORDS
) (
  input logic               clk,
  input logic               rst,
  input logic [FRAME_W-1:0] frame_o,
  input logic               frame_stb_o,
  input logic               locked_o,
  input logic [OFF_W-1:0]   slip_o
);

  localparam int GAP_W = $clog2(FRAME_WORDS + 1);
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)                             gap <= GAP_W'(FRAME_WORDS);
    else if (frame_stb_o)                gap <= '0;
    else if (gap < GAP_W'(FRAME_WORDS))  gap <= gap + 1'b1;
  end

  p_slip_step_r3: assert property (@(posedge clk) disable iff (rst)
    (slip_o != $past(slip_o)) |->
      (!$past(locked_o) &&
       slip_o == (($past(slip_o) == OFF_W'(WORD_W - 1)) ? '0 : OFF_W'($past(slip_o) + 1'b1))));

  p_settle_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(slip_o) != $past(slip_o, 2)) |-> (slip_o == $past(slip_o)));

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (locked_o && $past(locked_o)) |-> $stable(slip_o));

  p_stb_lock_r9: assert property (@(posedge clk) disable iff (rst)
    frame_stb_o |-> $past(locked_o));

  p_stb_gap_r9: assert property (@(posedge clk) disable iff (rst)
    frame_stb_o |-> (gap >= GAP_W'(FRAME_WORDS - 1)));

  p_frame_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !frame_stb_o |-> $stable(frame_o));

endmodule

bind rx_frame_gearbox rxg_checker #(
  .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .OFF_W(OFF_W), .FRAME_W(FRAME_W)
) u_rxg_checker (
  .clk         (clk),
  .rst         (rst),
  .frame_o     (frame_o),
  .frame_stb_o (frame_stb_o),
  .locked_o    (locked_o),
  .slip_o      (slip_o)
);

// File: tb/rx_frame_gearbox_bench.sv
`timescale 1ns/1ps
module rx_frame_gearbox_bench;

  localparam int W  = 20;
  localparam int FW = 6;
  localparam int FB = W * FW;
  localparam int NF = 600;
  localparam int CORRUPT_AT = 300;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  din = '0;
  logic [FB-1:0] frame;
  logic          stb, locked;
  logic [4:0]    slip;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int dpre    = 0;
  logic [FB-1:0] tx [0:NF+1];

  always #2.5 clk = ~clk;

  rx_frame_gearbox u_rx_frame_gearbox (
    .clk(clk), .rst(rst), .word_i(din), .frame_o(frame),
    .frame_stb_o(stb), .locked_o(locked), .slip_o(slip)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic bit_at(input int p);
    int rel;
    if (p < dpre) return logic'(((p * 13 + 5) % 7) < 3);
    rel = p - dpre;
    return tx[rel / FB][FB - 1 - (rel % FB)];
  endfunction

  function automatic logic [W-1:0] word_at(input int k);
    logic [W-1:0] w;
    for (int b = 0; b < W; b++) w[W-1-b] = bit_at(k * W + b);
    return w;
  endfunction

  // R2: headers drawn from both valid codes, 4'b0101 and 4'b0110
  task automatic fill_tx();
    logic [127:0] r;
    for (int i = 0; i <= NF + 1; i++) begin
      r = {$urandom(), $urandom(), $urandom(), $urandom()};
      tx[i] = {($urandom_range(1, 0) == 0) ? 4'b0101 : 4'b0110, r[FB-5:0]};
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk(!locked && !stb && slip == 0 && frame == '0, "R11 reset state",
        {locked, stb, slip}, 0);
  endtask

  task automatic run(input int d, input int n_bad);
    int first_lock = -1, relock = -1, drop_k = -1, drops = 0;
    int last_stb = -1, nxt = 0, nframes = 0;
    int r1_bad = 0, r3_bad = 0, r7_bad = 0, r8_bad = 0, r9_bad = 0, r10_bad = 0;
    int last_slip_k = -10;
    bit synced = 0, found;
    logic          p_locked = 1'b0;
    logic [4:0]    p_slip = '0;
    logic [FB-1:0] p_frame = '0;
    dpre = d;
    fill_tx();
    for (int i = CORRUPT_AT; i < CORRUPT_AT + n_bad; i++) tx[i][FB-1 -: 4] = 4'b0011;
    do_reset();
    for (int k = 0; k < NF * FW; k++) begin
      @(negedge clk);
      if (locked && !p_locked) begin
        if (first_lock < 0) first_lock = k; else relock = k;
        last_stb = -1;
        synced = 0;
      end
      if (!locked && p_locked) begin drops++; drop_k = k; end
      if (slip != p_slip) begin
        if (p_locked || slip != ((p_slip == 5'd19) ? 5'd0 : p_slip + 5'd1)) r3_bad++;
        if (k - last_slip_k <= 2) r7_bad++;
        if (locked && p_locked) r8_bad++;
        last_slip_k = k;
      end
      if (!stb && frame != p_frame) r10_bad++;
      if (stb) begin
        if (last_stb >= 0 && k - last_stb != FW) r9_bad++;
        last_stb = k;
        if (!synced) begin
          found = 0;
          for (int j = 0; j <= NF + 1; j++) begin
            if (!found && frame == tx[j]) begin found = 1; nxt = j + 1; end
          end
          if (found) synced = 1; else r1_bad++;
        end else if (nxt <= NF + 1) begin
          if (frame !== tx[nxt]) r1_bad++;
          nxt++;
          nframes++;
        end
      end
      p_locked = locked;
      p_slip   = slip;
      p_frame  = frame;
      din = word_at(k);
    end
    chk(first_lock >= 0 && first_lock <= 150 * FW, "R4 lock within bound (cycle)", first_lock, 150 * FW);
    chk(first_lock >= 31 * FW, "R5 no lock before 32 headers", first_lock, 31 * FW);
    chk(slip == 5'(d % W), "R3 final offset equals header bit position", slip, d % W);
    chk(r3_bad == 0, "R3 offset steps", r3_bad, 0);
    chk(r1_bad == 0 && nframes >= 50, "R1 R2 recovered frames match", r1_bad, 0);
    chk(r7_bad == 0, "R7 settle between slips", r7_bad, 0);
    chk(r8_bad == 0, "R8 offset frozen while locked", r8_bad, 0);
    chk(r9_bad == 0, "R9 strobe spacing", r9_bad, 0);
    chk(r10_bad == 0, "R10 frame holds between strobes", r10_bad, 0);
    if (n_bad == 3) chk(drops == 0, "R6 three bad headers keep lock", drops, 0);
    if (n_bad == 4) begin
      chk(drops == 1, "R6 four bad headers drop lock", drops, 1);
      chk(locked, "R6 lock regained", locked, 1);
      chk(relock - drop_k >= 31 * FW, "R5 relock needs 32 headers", relock - drop_k, 31 * FW);
    end
  endtask

  initial begin
    void'($urandom(32'd4021));
    run(0, 3);
    run(119, 4);
    run(int'($urandom_range(119, 0)), 0);
    run(int'($urandom_range(119, 0)), 0);
    run(37, 4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule